// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides, for every CAN frame that the receiver has finished without error, whether the frame goes into the receive queue or is thrown away. A frame that is thrown away has still been acknowledged on the bus. The decision is made by comparing the frame's identifier against a small bank of filters. Each filter has its own enable, a mask and a reference identifier. The number of filters present is a build parameter that may be zero to four.

The receiver presents the base identifier, the identifier extension, the format bit and the remote-request bit, and pulses a completion strobe. One clock later the block either raises a one-cycle store strobe or stays silent. With the store strobe it reports which filter accepted the frame when a filter did. The comparison also covers the format and remote-request bits, so a filter can be set to pass only extended frames or only data frames.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `store_stb`, `hit_valid` and `hit_idx` are all zero.
- R2: `store_stb` is a one-clock pulse that follows an accepted `frame_done` by exactly one clock, with one pulse for each accepted frame, including frames on back-to-back cycles. It is never high in a cycle that does not follow a `frame_done`.
- R3: A filter matches when every key bit whose mask bit is 1 equals the corresponding bit of that filter's identifier register. Key bits whose mask bit is 0 do not affect the match.
- R4: The comparison key is 31 bits wide: bit 30 is the format bit (1 = extended), bit 29 is the remote-request bit, bits 28:18 are the 11-bit base identifier and bits 17:0 are the 18-bit extension. Mask and identifier registers use the same layout, with filter i at bits [31*i+30 : 31*i] of the flat buses.
- R5: For a frame whose format bit is 0, the extension field of the key is taken as zero, whatever is present on `rx_ext_id`.
- R6: When at least one built filter is enabled, a frame is stored only if at least one enabled built filter matches it. Otherwise no store strobe follows.
- R7: When no built filter is enabled, every frame is stored and `hit_valid` stays low.
- R8: With `NUM_FILT` set to 0, every frame is stored and `hit_valid` stays low, whatever the enable, mask and identifier inputs are.
- R9: When a frame is stored because of a match, `hit_valid` is high with `store_stb` and `hit_idx` gives the lowest-numbered enabled filter that matched. At all other times `hit_idx` is zero.
- R10: The enable, mask and identifier inputs of filter positions at or above `NUM_FILT` have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_done | input | 1 | One-cycle strobe: a frame has been received correctly |
| rx_base_id | input | 11 | Base identifier of the received frame |
| rx_ext_id | input | 18 | Identifier extension (used only for extended frames) |
| rx_ide | input | 1 | Format bit, 1 = extended frame |
| rx_rtr | input | 1 | Remote-request bit |
| filt_en | input | 4 | Per-filter enable |
| filt_mask | input | 124 | Four 31-bit masks, filter i at bits [31*i+30:31*i] |
| filt_id | input | 124 | Four 31-bit reference identifiers, same layout |
| store_stb | output | 1 | One-cycle pulse: write the frame into the receive queue |
| hit_valid | output | 1 | High with store_stb when a filter match caused the store |
| hit_idx | output | 2 | Index of the lowest matching enabled filter |

## Verification
The bench drives one stimulus into instances built with four, two and zero filters. A model compares their outputs on every clock. A standard frame carries garbage in the extension field: a design that compared those bits would drop frames that ought to pass. Filters that differ only in the format or remote-request bit show whether those bits are left out of the comparison. Several filters match at once, which exposes a wrong priority order as the wrong index. Enables set above the built count expose a design that lets unbuilt filters reject frames. With every filter disabled, a design that treats an empty enable set as "reject all" would raise no store strobe.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int MAX_FILT = 4;
    localparam int BASE_W   = 11;
    localparam int EXT_W    = 18;
    localparam int KEY_W    = 2 + BASE_W + EXT_W;
    localparam int IDX_W    = $clog2(MAX_FILT);

    typedef struct packed {
        logic              ide;
        logic              rtr;
        logic [BASE_W-1:0] base;
        logic [EXT_W-1:0]  ext;
    } filt_key_t;

    typedef struct packed {
        logic             accept;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } filt_decision_t;

    function automatic logic key_match(input filt_key_t key,
                                       input logic [KEY_W-1:0] ref_id,
                                       input logic [KEY_W-1:0] mask);
        return ((key ^ ref_id) & mask) == '0;
    endfunction
endpackage

// File: rtl/can_filt_keygen.sv
module can_filt_keygen
    import can_filt_pkg::*;
(
    input  logic [BASE_W-1:0] base_id,
    input  logic [EXT_W-1:0]  ext_id,
    input  logic              ide,
    input  logic              rtr,
    output filt_key_t         key
);
    always_comb begin
        key.ide  = ide;
        key.rtr  = rtr;
        key.base = base_id;
        key.ext  = ide ? ext_id : '0;
    end
endmodule

// File: rtl/can_filt_cmp.sv
module can_filt_cmp
    import can_filt_pkg::*;
#(
    parameter int NUM_FILT = 4
) (
    input  filt_key_t                   key,
    input  logic [MAX_FILT-1:0]         en,
    input  logic [MAX_FILT*KEY_W-1:0]   mask_flat,
    input  logic [MAX_FILT*KEY_W-1:0]   id_flat,
    output logic [MAX_FILT-1:0]         hits,
    output logic                        any_en
);
    logic [MAX_FILT-1:0] built_en;

    for (genvar i = 0; i < MAX_FILT; i++) begin : g_filt
        if (i < NUM_FILT) begin : g_built
            assign built_en[i] = en[i];
            assign hits[i]     = en[i] &&
                key_match(key, id_flat[i*KEY_W +: KEY_W], mask_flat[i*KEY_W +: KEY_W]);
        end else begin : g_absent
            assign built_en[i] = 1'b0;
            assign hits[i]     = 1'b0;
        end
    end

    assign any_en = |built_en;
endmodule

// File: rtl/can_filt_arbiter.sv
module can_filt_arbiter
    import can_filt_pkg::*;
(
    input  logic [MAX_FILT-1:0] hits,
    input  logic                any_en,
    output filt_decision_t      dec
);
    always_comb begin
        dec.hit    = |hits;
        dec.accept = !any_en || dec.hit;
        dec.idx    = '0;
        for (int i = MAX_FILT - 1; i >= 0; i--) begin
            if (hits[i]) dec.idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_FILT = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frame_done,
    input  logic [BASE_W-1:0]            rx_base_id,
    input  logic [EXT_W-1:0]             rx_ext_id,
    input  logic                         rx_ide,
    input  logic                         rx_rtr,
    input  logic [MAX_FILT-1:0]          filt_en,
    input  logic [MAX_FILT*KEY_W-1:0]    filt_mask,
    input  logic [MAX_FILT*KEY_W-1:0]    filt_id,
    output logic                         store_stb,
    output logic                         hit_valid,
    output logic [IDX_W-1:0]             hit_idx
);
    filt_key_t           key;
    logic [MAX_FILT-1:0] hits;
    logic                any_en;
    filt_decision_t      dec;

    can_filt_keygen u_keygen (
        .base_id (rx_base_id),
        .ext_id  (rx_ext_id),
        .ide     (rx_ide),
        .rtr     (rx_rtr),
        .key     (key)
    );

    can_filt_cmp #(.NUM_FILT(NUM_FILT)) u_cmp (
        .key       (key),
        .en        (filt_en),
        .mask_flat (filt_mask),
        .id_flat   (filt_id),
        .hits      (hits),
        .any_en    (any_en)
    );

    can_filt_arbiter u_arb (
        .hits   (hits),
        .any_en (any_en),
        .dec    (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            store_stb <= 1'b0;
            hit_valid <= 1'b0;
            hit_idx   <= '0;
        end else begin
            store_stb <= frame_done && dec.accept;
            hit_valid <= frame_done && dec.hit;
            hit_idx   <= (frame_done && dec.hit) ? dec.idx : '0;
        end
    end
endmodule

// File: rtl/can_filt_checker.sv
module can_filt_checker
    import can_filt_pkg::*;
#(
    parameter int NUM_FILT = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                frame_done,
    input logic [MAX_FILT-1:0] filt_en,
    input logic                store_stb,
    input logic                hit_valid,
    input logic [IDX_W-1:0]    hit_idx
);
    localparam logic [MAX_FILT-1:0] BUILT =
        (NUM_FILT >= MAX_FILT) ? {MAX_FILT{1'b1}} : MAX_FILT'((1 << NUM_FILT) - 1);

    AST_NO_SPURIOUS_STORE: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> !store_stb);                                   // R2
    AST_HIT_WITH_STORE: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> store_stb);                                      // R9
    AST_IDX_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> hit_idx == '0);                                 // R9
    AST_IDX_BUILT: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> int'(hit_idx) < NUM_FILT);                       // R10
    AST_OPEN_WHEN_NONE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (frame_done && (filt_en & BUILT) == '0) |=> (store_stb && !hit_valid)); // R7
endmodule

bind can_accept_filter can_filt_checker #(.NUM_FILT(NUM_FILT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .filt_en    (filt_en),
    .store_stb  (store_stb),
    .hit_valid  (hit_valid),
    .hit_idx    (hit_idx)
);

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
    import can_filt_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              frame_done = 1'b0;
    logic [10:0]       rx_base_id = '0;
    logic [17:0]       rx_ext_id  = '0;
    logic              rx_ide = 1'b0;
    logic              rx_rtr = 1'b0;
    logic [3:0]        filt_en = '0;
    logic [30:0]       fm [4];
    logic [30:0]       fi [4];
    logic [123:0]      mask_bus, id_bus;

    assign mask_bus = {fm[3], fm[2], fm[1], fm[0]};
    assign id_bus   = {fi[3], fi[2], fi[1], fi[0]};

    logic       s4, v4, s2, v2, s0, v0;
    logic [1:0] i4, i2, i0;

    can_accept_filter #(.NUM_FILT(4)) dut (
        .clk(clk), .rst(rst), .frame_done(frame_done), .rx_base_id(rx_base_id),
        .rx_ext_id(rx_ext_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr), .filt_en(filt_en),
        .filt_mask(mask_bus), .filt_id(id_bus),
        .store_stb(s4), .hit_valid(v4), .hit_idx(i4));
    can_accept_filter #(.NUM_FILT(2)) dut_two (
        .clk(clk), .rst(rst), .frame_done(frame_done), .rx_base_id(rx_base_id),
        .rx_ext_id(rx_ext_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr), .filt_en(filt_en),
        .filt_mask(mask_bus), .filt_id(id_bus),
        .store_stb(s2), .hit_valid(v2), .hit_idx(i2));
    can_accept_filter #(.NUM_FILT(0)) dut_none (
        .clk(clk), .rst(rst), .frame_done(frame_done), .rx_base_id(rx_base_id),
        .rx_ext_id(rx_ext_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr), .filt_en(filt_en),
        .filt_mask(mask_bus), .filt_id(id_bus),
        .store_stb(s0), .hit_valid(v0), .hit_idx(i0));

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Behavioural reference: decision for a bank of n filters
    task automatic model(int n, output int st, output int hv, output int hx);
        logic [30:0] k;
        int first = -1;
        bit any = 0;
        k = {rx_ide, rx_rtr, rx_base_id, (rx_ide ? rx_ext_id : 18'd0)};
        for (int f = 0; f < n; f++) begin
            if (filt_en[f]) begin
                any = 1;
                if ((((k ^ fi[f]) & fm[f]) == 31'd0) && first < 0) first = f;
            end
        end
        st = frame_done && (!any || first >= 0);
        hv = frame_done && first >= 0;
        hx = hv ? first : 0;
    endtask

    task automatic step(string tag);
        int es4, ev4, ex4, es2, ev2, ex2, es0, ev0, ex0;
        @(posedge clk);
        model(4, es4, ev4, ex4);
        model(2, es2, ev2, ex2);
        model(0, es0, ev0, ex0);
        @(negedge clk);
        check(tag, "stb4", int'(s4), es4);
        check(tag, "hit4", int'(v4), ev4);
        check(tag, "idx4", int'(i4), ex4);
        check(tag, "stb2", int'(s2), es2);
        check(tag, "hit2", int'(v2), ev2);
        check(tag, "idx2", int'(i2), ex2);
        check(tag, "stb0", int'(s0), es0);
        check(tag, "hit0", int'(v0), ev0);
        check(tag, "idx0", int'(i0), ex0);
        frame_done = 1'b0;
    endtask

    task automatic frame(string tag, logic ide, logic rtr, logic [10:0] b, logic [17:0] e);
        rx_ide = ide; rx_rtr = rtr; rx_base_id = b; rx_ext_id = e;
        frame_done = 1'b1;
        step(tag);
    endtask

    function automatic logic [30:0] key(logic ide, logic rtr, logic [10:0] b, logic [17:0] e);
        return {ide, rtr, b, e};
    endfunction

    initial begin
        for (int f = 0; f < 4; f++) begin fm[f] = '0; fi[f] = '0; end
        repeat (2) @(negedge clk);
        check("R1", "stb in reset", int'(s4), 0);
        check("R1", "hit in reset", int'(v4), 0);
        check("R1", "idx in reset", int'(i4), 0);
        rst = 1'b0;
        step("R1");
        step("R2");

        // no filter enabled: accept all
        frame("R7", 1'b0, 1'b0, 11'h055, 18'h0);
        frame("R7", 1'b1, 1'b1, 11'h7FF, 18'h3FFFF);

        // filter 0 exact on standard id 0x123
        fm[0] = 31'h7FFF_FFFF; fi[0] = key(1'b0, 1'b0, 11'h123, 18'h0);
        filt_en = 4'b0001;
        frame("R5", 1'b0, 1'b0, 11'h123, 18'h2ABCD);
        frame("R6", 1'b0, 1'b0, 11'h124, 18'h0);
        frame("R4", 1'b0, 1'b1, 11'h123, 18'h0);
        step("R2");

        // mask with low nibble ignored
        fm[0] = key(1'b1, 1'b1, 11'h7F0, 18'h3FFFF);
        frame("R3", 1'b0, 1'b0, 11'h12E, 18'h0);
        frame("R3", 1'b0, 1'b0, 11'h133, 18'h0);

        // format-only filter: extended frames only
        fm[0] = key(1'b1, 1'b0, 11'h0, 18'h0); fi[0] = key(1'b1, 1'b0, 11'h0, 18'h0);
        frame("R4", 1'b0, 1'b0, 11'h001, 18'h0);
        frame("R4", 1'b1, 1'b0, 11'h001, 18'h1234);
        // remote-only filter
        fm[0] = key(1'b0, 1'b1, 11'h0, 18'h0); fi[0] = key(1'b0, 1'b1, 11'h0, 18'h0);
        frame("R4", 1'b1, 1'b0, 11'h3, 18'h5);
        frame("R4", 1'b0, 1'b1, 11'h3, 18'h5);

        // several matches: lowest enabled wins; back-to-back frames
        fm[1] = '0; fm[3] = '0; fm[2] = 31'h7FFF_FFFF; fi[2] = key(1'b1, 1'b0, 11'h444, 18'h1);
        filt_en = 4'b1010;
        frame("R9", 1'b0, 1'b0, 11'h10, 18'h0);
        filt_en = 4'b1000;
        frame("R9", 1'b0, 1'b0, 11'h10, 18'h0);
        filt_en = 4'b1100;
        frame("R9", 1'b1, 1'b0, 11'h444, 18'h1);
        frame("R2", 1'b1, 1'b0, 11'h444, 18'h2);

        // enables above built count
        filt_en = 4'b0100;
        frame("R10", 1'b0, 1'b0, 11'h99, 18'h0);
        frame("R8", 1'b1, 1'b1, 11'h444, 18'h1);

        // mixed pseudo-random traffic
        begin
            int unsigned lcg = 32'h1234_5678;
            for (int f = 0; f < 4; f++) begin
                lcg = lcg * 1664525 + 1013904223; fi[f] = lcg[30:0];
                lcg = lcg * 1664525 + 1013904223; fm[f] = lcg[30:0] & 31'h6000_3F00;
            end
            for (int n = 0; n < 300; n++) begin
                lcg = lcg * 1664525 + 1013904223;
                filt_en = lcg[3:0];
                rx_ide = lcg[4]; rx_rtr = lcg[5]; rx_base_id = lcg[16:6];
                rx_ext_id = {lcg[31:17], 3'b0};
                frame_done = lcg[7] | lcg[9];
                step("R6");
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule